// File: doc/BRIEF.md
# Up/down counter with carry tick

A synchronous binary counter with a parameterized width and a non-zero power-up value. On each rising clock edge it holds, steps up by one or steps down by one, as chosen by an enable input and a direction input. It wraps around in both directions. The default build is 10 bits wide, covering 0 to 1023, and starts from 300.

A one-cycle terminal tick is produced next to the count. It is not built from a wide all-ones comparator. The increment path is one bit wider than the counter, and its top bit is the tick. That bit is the carry out of the register, and it is set only while the count is at its maximum and the next edge will wrap it to 0. The tick is also qualified by the operation in force, so it stays low while the counter holds, counts down or is in reset.

Each cycle a small decoder selects one of three step operations from reset, enable and direction:

- `OP_HOLD` is used during reset, or when enable is low.
- `OP_INC` is used when enable is high and direction is up.
- `OP_DEC` is used when enable is high and direction is down.

The decoder has no memory, so any operation can follow any other on the next cycle. The decoded operation then sets the transition of the count register:

- `OP_INC` loads count+1.
- `OP_DEC` loads count−1.
- `OP_HOLD` keeps the count.
- Reset overrides all three and loads the start value.

Top module: `updn_carry_counter`

## Requirements
- R1: While `rst_i` is 1 at a rising edge, the count becomes `START` (300 by default) after that edge, whatever `en_i` and `up_i` are. `tick_o` is 0 during reset.
- R2: Before any clock edge, the count already equals `START`.
- R3: With `en_i`=0 the count holds its value across edges, for either value of `up_i`.
- R4: With `en_i`=1 and `up_i`=1 the count rises by exactly one per edge.
- R5: With `en_i`=1 and `up_i`=0 the count falls by exactly one per edge.
- R6: Counting up from the maximum (all ones, 1023 by default) gives 0 on the next edge.
- R7: Counting down from 0 gives the maximum on the next edge.
- R8: In every cycle, `tick_o` is 1 exactly when `rst_i`=0, `en_i`=1, `up_i`=1 and the count equals the maximum. It is combinational from the current count and inputs.
- R9: `tick_o` is 0 whenever `en_i`=0 or `up_i`=0, including while the count sits at the maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high, reloads `START` |
| en_i | input | 1 | 1 steps the counter, 0 holds it |
| up_i | input | 1 | 1 counts upward, 0 counts downward |
| count_o | output | WIDTH | Current count |
| tick_o | output | 1 | Carry-out tick, high in the cycle before an upward wrap |

## Verification
Two functions can fall in the same cycle: a synchronous reset and the upward wrap that would raise the tick. To provoke this, the bench counts the register up to its maximum, keeps enable and up direction high, and then asserts reset. It judges the result in two places. First, the tick must be low in that cycle even though the count is all ones. Second, the count after the edge must be the start value and not 0. The other overlap, the tick together with the wrap itself, is judged by requiring the tick high at the maximum and the count 0 one edge later. A free-running monitor also compares the tick against an equality compare with the maximum in every cycle.

// File: rtl/updn_pkg.sv
package updn_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2
    } step_op_e;
endpackage

// File: rtl/updn_step_decode.sv
module updn_step_decode
    import updn_pkg::*;
(
    input  logic     rst_i,
    input  logic     en_i,
    input  logic     up_i,
    output step_op_e op_o
);
    always_comb begin
        op_o = OP_HOLD;
        if (!rst_i) begin
            unique case ({en_i, up_i})
                2'b11:   op_o = OP_INC;
                2'b10:   op_o = OP_DEC;
                default: op_o = OP_HOLD;
            endcase
        end
    end
endmodule

// File: rtl/updn_next_adder.sv
module updn_next_adder
    import updn_pkg::*;
#(
    parameter int WIDTH = 10
) (
    input  logic [WIDTH-1:0] cur_i,
    input  step_op_e         op_i,
    output logic [WIDTH-1:0] nxt_o,
    output logic             carry_o
);
    localparam logic [WIDTH:0]   ONE_WIDE = {{WIDTH{1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH:0]   inc_wide;
    logic [WIDTH-1:0] dec_val;

    // Increment one bit wider than the register: the top bit is the carry out.
    assign inc_wide = {1'b0, cur_i} + ONE_WIDE;
    assign dec_val  = cur_i - ONE;
    assign carry_o  = inc_wide[WIDTH];

    always_comb begin
        unique case (op_i)
            OP_INC:  nxt_o = inc_wide[WIDTH-1:0];
            OP_DEC:  nxt_o = dec_val;
            default: nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/updn_carry_counter.sv
module updn_carry_counter
    import updn_pkg::*;
#(
    parameter int WIDTH = 10,
    parameter int START = 300
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             up_i,
    output logic [WIDTH-1:0] count_o,
    output logic             tick_o
);
    localparam logic [WIDTH-1:0] START_V = WIDTH'(START);

    step_op_e         op;
    logic [WIDTH-1:0] nxt;
    logic             carry;
    logic [WIDTH-1:0] cnt_q = START_V;

    updn_step_decode u_decode (
        .rst_i (rst_i),
        .en_i  (en_i),
        .up_i  (up_i),
        .op_o  (op)
    );

    updn_next_adder #(.WIDTH(WIDTH)) u_adder (
        .cur_i   (cnt_q),
        .op_i    (op),
        .nxt_o   (nxt),
        .carry_o (carry)
    );

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= START_V;
        else       cnt_q <= nxt;
    end

    // Outputs
    always_comb begin
        count_o = cnt_q;
        tick_o  = carry && (op == OP_INC);
    end
endmodule

// File: rtl/updn_carry_counter_chk.sv
module updn_carry_counter_chk #(
    parameter int WIDTH = 10,
    parameter int START = 300
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             en_i,
    input logic             up_i,
    input logic [WIDTH-1:0] count_o,
    input logic             tick_o
);
    localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

    // R3
    hold_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(count_o));

    // R4
    step_up_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && up_i) |=> (count_o == $past(count_o) + ONE));

    // R5
    step_down_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !up_i) |=> (count_o == $past(count_o) - ONE));

    // R6
    wrap_after_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |=> (count_o == '0));

    // R8
    tick_match_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o == (en_i && up_i && count_o == MAXV));

    // R9
    tick_qual_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |-> (en_i && up_i));
endmodule

bind updn_carry_counter updn_carry_counter_chk #(.WIDTH(WIDTH), .START(START)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (en_i),
    .up_i    (up_i),
    .count_o (count_o),
    .tick_o  (tick_o)
);

// File: tb/updn_carry_counter_tb.sv
`timescale 1ns/1ps
module updn_carry_counter_tb;
    localparam int W    = 10;
    localparam int ST   = 300;
    localparam int MAXV = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic up  = 1'b0;
    logic [W-1:0] count;
    logic tick;
    int tests = 0;
    int fails = 0;
    int mon_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    updn_carry_counter #(.WIDTH(W), .START(ST)) u_dut (
        .clk_i(clk), .rst_i(rst), .en_i(en), .up_i(up),
        .count_o(count), .tick_o(tick)
    );

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R8: carry tick versus equality compare, every cycle
    always @(negedge clk) begin
        #2;
        if (tick !== (!rst && en && up && (count == W'(MAXV)))) mon_bad++;
    end

    // Set inputs at a negedge, run n edges, end at a negedge.
    task automatic run(bit r, bit e, bit u, int n);
        rst = r; en = e; up = u;
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic t_powerup();
        check("R2 power-up count", int'(count), ST);
    endtask

    task automatic t_reset();
        run(1'b1, 1'b1, 1'b1, 2);
        check("R1 reset count", int'(count), ST);
        check("R1 tick in reset", int'(tick), 0);
    endtask

    task automatic t_hold();
        run(1'b0, 1'b0, 1'b1, 5);
        check("R3 hold up_i=1", int'(count), ST);
        run(1'b0, 1'b0, 1'b0, 5);
        check("R3 hold up_i=0", int'(count), ST);
    endtask

    task automatic t_up_down();
        run(1'b0, 1'b1, 1'b1, 7);
        check("R4 count up 7", int'(count), ST + 7);
        run(1'b0, 1'b1, 1'b0, 10);
        check("R5 count down 10", int'(count), ST - 3);
    endtask

    task automatic t_wrap_up();
        run(1'b1, 1'b0, 1'b0, 1);
        run(1'b0, 1'b1, 1'b1, MAXV - ST);
        check("R4 reach max", int'(count), MAXV);
        check("R8 tick at max", int'(tick), 1);
        run(1'b0, 1'b1, 1'b1, 1);
        check("R6 wrap to 0", int'(count), 0);
        check("R8 tick at 0", int'(tick), 0);
    endtask

    task automatic t_wrap_down();
        run(1'b0, 1'b1, 1'b0, 1);
        check("R7 wrap to max", int'(count), MAXV);
        check("R9 tick counting down at max", int'(tick), 0);
        run(1'b0, 1'b0, 1'b1, 1);
        check("R9 tick holding at max", int'(tick), 0);
        check("R3 hold at max", int'(count), MAXV);
    endtask

    task automatic t_reset_at_max();
        rst = 1'b1; en = 1'b1; up = 1'b1;
        #1;
        check("R1 tick low with reset at max", int'(tick), 0);
        @(negedge clk); #1;
        check("R1 reset wins over wrap", int'(count), ST);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R4 count after reset", int'(count), ST + 1);
    endtask

    initial begin
        #1;
        t_powerup();
        @(negedge clk);
        t_reset();
        t_hold();
        t_up_down();
        t_wrap_up();
        t_wrap_down();
        t_reset_at_max();
        check("R8 tick/compare mismatches", mon_bad, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200us;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule